// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the bus master for a single-lane serial link to a two-channel successive-approximation converter. A start request drops the active-low chip select, which makes the converter take its analog sample. The block then produces 16 serial clocks in mode 0: the clock idles low, the converter moves its data line on each falling edge and the reader takes the bit on each rising edge. The serial clock comes from the system clock through a divider whose half period is a parameter.

The frame is read MSB first. It opens with a header of three fixed ones, then the channel identifier, then the ten result bits from D9 down to D0, then two trailing sub-bits. When the frame ends, the block checks the header. A correct header makes the new fields visible on the outputs and sets frame-valid. A bad header raises the error flag and leaves the held result as it was. A one-cycle done pulse marks the end of each frame. Chip select then stays high for a set minimum time before the block takes a new request.

The block can be built to read the frame as two 8-bit transfers. Between the bytes it holds the clock low for a few extra cycles while chip select stays low.

Top module: `adc_frame_reader`

## Requirements
- R1: Reset state: cs_n is 1, sclk is 0, busy, done, frame_valid and frame_err are 0, and sample, chan_id and sub_bits are all zero.
- R2: Whenever cs_n is 1, sclk is 0.
- R3: After cs_n falls, sclk stays low for exactly HALF_CYC system clocks before its first rising edge. Every high phase of sclk lasts exactly HALF_CYC system clocks.
- R4: Each frame has exactly 16 rising sclk edges. After the 16th falling edge, cs_n stays low for HALF_CYC more system clocks before it rises.
- R5: With SPLIT_BYTES set, the low phase after the 8th falling edge lasts HALF_CYC+BYTE_GAP system clocks, and cs_n stays low throughout.
- R6: The sdi bits taken on rising edges 1..16 form a word w[15:0], first bit in w[15]. The fields are: header w[15:13], chan_id w[12], sample w[11:2] (w[11] = D9), sub_bits w[1:0] (w[1] = S1).
- R7: If the header reads 3'b111, then in the done cycle frame_valid=1, frame_err=0, and sample, chan_id and sub_bits take the new fields.
- R8: If the header is not 3'b111, then in the done cycle frame_err=1, frame_valid=0, and sample, chan_id and sub_bits keep their previous values.
- R9: done is high for exactly one system clock per frame, in the cycle where cs_n rises.
- R10: A start is taken only when busy is 0. busy is 1 from the cycle after the start is taken until the chip-select gap ends. A start while busy has no effect.
- R11: Between two frames, cs_n stays high for at least CS_GAP system clocks.
- R12: sdi is ignored while cs_n is 1. Toggling it does not change any output.
- R13: CLK_HZ/(2*HALF_CYC) must not exceed SCLK_MAX_HZ, the converter's 2.17 MHz limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to read one frame |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, mode 0 |
| busy | output | 1 | A frame or the chip-select gap is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| frame_valid | output | 1 | Last frame had a correct header |
| frame_err | output | 1 | Last frame had a bad header |
| sample | output | 10 | Held conversion result |
| chan_id | output | 1 | Held channel identifier |
| sub_bits | output | 2 | Held sub-bits S1, S0 |

## Verification
The assertions assume that rst_n is held low long enough to load the reset values, and that start is a synchronous level. They place no limit on how often start is raised. The stimulus raises start both while the block is idle and in the middle of a frame. The bench converter model changes sdi only on falling sclk edges or when cs_n falls, and it toggles sdi freely while cs_n is high, so every sample point sees a settled bit.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

    localparam int FRAME_LEN = 16;
    localparam int BYTE_LEN  = 8;
    localparam logic [2:0] HDR_ONES = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_PAUSE,
        ST_TAIL,
        ST_GAP
    } rd_state_e;

    // bit layout of one received frame, MSB received first
    typedef struct packed {
        logic [2:0] hdr;
        logic       chan;
        logic [9:0] data;
        logic [1:0] sub;
    } adc_frame_t;

endpackage

// File: rtl/adcr_halfdiv.sv
module adcr_halfdiv #(
    parameter int HALF_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/adcr_shreg.sv
module adcr_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         sdi,
    output logic [W-1:0] word
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clr)        sh_d = '0;
        else if (shift) sh_d = {sh_q[W-2:0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word = sh_q;

endmodule

// File: rtl/adcr_unpack.sv
module adcr_unpack
    import adcr_pkg::*;
(
    input  logic [FRAME_LEN-1:0] word,
    output adc_frame_t           fields,
    output logic                 hdr_ok
);
    always_comb begin
        fields = adc_frame_t'(word);
        hdr_ok = (fields.hdr == HDR_ONES);
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcr_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SCLK_MAX_HZ = 2_170_000,
    parameter int HALF_CYC    = 12,
    parameter int CS_GAP      = 20,
    parameter int SPLIT_BYTES = 0,
    parameter int BYTE_GAP    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       sdi,
    output logic       cs_n,
    output logic       sclk,
    output logic       busy,
    output logic       done,
    output logic       frame_valid,
    output logic       frame_err,
    output logic [9:0] sample,
    output logic       chan_id,
    output logic [1:0] sub_bits
);
    localparam int BW       = $clog2(FRAME_LEN + 1);
    localparam int WMAX     = (CS_GAP > BYTE_GAP) ? CS_GAP : BYTE_GAP;
    localparam int WW       = (WMAX > 1) ? $clog2(WMAX + 1) : 1;
    localparam logic [WW-1:0] GAP_LAST   = WW'((CS_GAP > 0) ? CS_GAP - 1 : 0);
    localparam logic [WW-1:0] PAUSE_LAST = WW'((BYTE_GAP > 0) ? BYTE_GAP - 1 : 0);
    localparam logic [BW-1:0] NB_FULL    = BW'(FRAME_LEN);
    localparam logic [BW-1:0] NB_HALF    = BW'(BYTE_LEN);
    localparam bit SPLIT_ON = (SPLIT_BYTES != 0);

    typedef struct packed {
        rd_state_e     st;
        logic          cs_n;
        logic          sclk;
        logic [BW-1:0] nbits;
        logic [WW-1:0] wcnt;
        logic          done;
        logic          valid;
        logic          err;
        logic [9:0]    data;
        logic          chan;
        logic [1:0]    sub;
    } rd_reg_t;

    localparam rd_reg_t RESET_VAL = '{
        st: ST_IDLE, cs_n: 1'b1, sclk: 1'b0, nbits: '0, wcnt: '0,
        done: 1'b0, valid: 1'b0, err: 1'b0, data: '0, chan: 1'b0, sub: '0
    };

    rd_reg_t r_d, r_q;

    logic                 tick;
    logic                 div_run;
    logic                 take_start;
    logic                 rise_edge;
    logic [FRAME_LEN-1:0] rx_word;
    adc_frame_t           rx_fields;
    logic                 rx_hdr_ok;

    assign div_run    = (r_q.st == ST_SHIFT) || (r_q.st == ST_TAIL);
    assign take_start = (r_q.st == ST_IDLE) && start;
    assign rise_edge  = (r_q.st == ST_SHIFT) && tick && !r_q.sclk;

    adcr_halfdiv #(.HALF_CYC(HALF_CYC)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (div_run),
        .tick (tick)
    );

    adcr_shreg #(.W(FRAME_LEN)) u_shreg (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (take_start),
        .shift(rise_edge),
        .sdi  (sdi),
        .word (rx_word)
    );

    adcr_unpack u_unpack (
        .word  (rx_word),
        .fields(rx_fields),
        .hdr_ok(rx_hdr_ok)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_SHIFT;
                    r_d.cs_n  = 1'b0;
                    r_d.sclk  = 1'b0;
                    r_d.nbits = '0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk  = 1'b1;
                        r_d.nbits = r_q.nbits + 1'b1;
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.nbits == NB_FULL) begin
                            r_d.st = ST_TAIL;
                        end else if (SPLIT_ON && r_q.nbits == NB_HALF) begin
                            r_d.st   = ST_PAUSE;
                            r_d.wcnt = '0;
                        end
                    end
                end
            end
            ST_PAUSE: begin
                if (r_q.wcnt == PAUSE_LAST) r_d.st = ST_SHIFT;
                else                        r_d.wcnt = r_q.wcnt + 1'b1;
            end
            ST_TAIL: begin
                if (tick) begin
                    r_d.st   = ST_GAP;
                    r_d.cs_n = 1'b1;
                    r_d.done = 1'b1;
                    r_d.wcnt = '0;
                    if (rx_hdr_ok) begin
                        r_d.valid = 1'b1;
                        r_d.err   = 1'b0;
                        r_d.data  = rx_fields.data;
                        r_d.chan  = rx_fields.chan;
                        r_d.sub   = rx_fields.sub;
                    end else begin
                        r_d.valid = 1'b0;
                        r_d.err   = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (r_q.wcnt == GAP_LAST) r_d.st = ST_IDLE;
                else                      r_d.wcnt = r_q.wcnt + 1'b1;
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign cs_n        = r_q.cs_n;
    assign sclk        = r_q.sclk;
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign frame_valid = r_q.valid;
    assign frame_err   = r_q.err;
    assign sample      = r_q.data;
    assign chan_id     = r_q.chan;
    assign sub_bits    = r_q.sub;

    // ---------------- assertions and their support counters ----------------
    initial begin
        assert_rate_R13: assert ((CLK_HZ / (2 * HALF_CYC)) <= SCLK_MAX_HZ)
            else $error("serial clock rate above converter limit");
    end

    logic        chk_sclk_q;
    logic [31:0] chk_high_q;
    logic [31:0] chk_edges_q;
    logic [31:0] chk_cshi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_sclk_q  <= 1'b0;
            chk_high_q  <= '0;
            chk_edges_q <= '0;
            chk_cshi_q  <= 32'(CS_GAP);
        end else begin
            chk_sclk_q  <= sclk;
            chk_high_q  <= sclk ? chk_high_q + 1 : '0;
            if (cs_n)                    chk_edges_q <= '0;
            else if (sclk && !chk_sclk_q) chk_edges_q <= chk_edges_q + 1;
            if (!cs_n)                       chk_cshi_q <= '0;
            else if (chk_cshi_q < 32'hFFFF)  chk_cshi_q <= chk_cshi_q + 1;
        end
    end

    assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> chk_high_q == 32'(HALF_CYC));

    assert_sixteen_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> chk_edges_q == 32'(FRAME_LEN));

    assert_keep_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frame_err) |-> ($stable(sample) && $stable(chan_id) && $stable(sub_bits)));

    assert_done_with_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n));

    assert_start_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(r_q.st) == ST_IDLE && $past(start)));

    assert_min_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> chk_cshi_q >= 32'(CS_GAP));

endmodule

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;
    localparam int HALF_CYC = 12;
    localparam int CS_GAP   = 20;
    localparam int BYTE_GAP = 6;
    localparam int CLK_HZ   = 50_000_000;
    localparam int SMAX_HZ  = 2_170_000;

    typedef struct {
        logic       valid;
        logic       err;
        logic [9:0] data;
        logic       chan;
        logic [1:0] sub;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sdi;
    logic cs_n, sclk, busy, done, frame_valid, frame_err, chan_id;
    logic [9:0] sample;
    logic [1:0] sub_bits;

    int n_checks = 0;
    int n_fails  = 0;
    exp_t sb_q[$];
    exp_t held;

    always #10 clk = ~clk;

    adc_frame_reader #(
        .CLK_HZ(CLK_HZ), .SCLK_MAX_HZ(SMAX_HZ), .HALF_CYC(HALF_CYC),
        .CS_GAP(CS_GAP), .SPLIT_BYTES(1), .BYTE_GAP(BYTE_GAP)
    ) i_adc_frame_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .sdi(sdi),
        .cs_n(cs_n), .sclk(sclk), .busy(busy), .done(done),
        .frame_valid(frame_valid), .frame_err(frame_err),
        .sample(sample), .chan_id(chan_id), .sub_bits(sub_bits)
    );

    // converter model: bit out on cs fall, next bit on each falling sclk
    logic [15:0] tx_word = '0;
    logic so_bit = 1'b0;
    logic noise  = 1'b0;
    int   pos    = 0;
    always @(negedge cs_n) begin
        pos    = 15;
        so_bit = tx_word[15];
    end
    always @(negedge sclk) begin
        if (cs_n === 1'b0) begin
            pos    = pos - 1;
            so_bit = (pos >= 0) ? tx_word[pos[3:0]] : 1'b0;
        end
    end
    always @(negedge clk) noise <= ~noise;
    assign sdi = cs_n ? noise : so_bit;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [2:0] h, input logic c,
                                       input logic [9:0] d, input logic [1:0] s);
        return {h, c, d, s};
    endfunction

    // driver: loads model word, pushes expectation, pulses start
    task automatic run_frame(input logic [15:0] w, input bit spam);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        tx_word = w;
        if (w[15:13] == 3'b111) begin
            held.valid = 1'b1; held.err = 1'b0;
            held.data = w[11:2]; held.chan = w[12]; held.sub = w[1:0];
        end else begin
            held.valid = 1'b0; held.err = 1'b1;
        end
        e = held;
        sb_q.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (spam) begin
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy === 1'b1, "R10", "busy mid-frame", busy, 1);
        end
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // monitor: scoreboard compare on done, bus timing per frame
    logic prev_cs = 1'b1, prev_sclk = 1'b0;
    int lowc, highc, rises, lead, mid, hi_len;
    bit hbad, idle_bad, seen_frame;
    initial begin
        lowc = 0; highc = 0; rises = 0; lead = 0; mid = 0; hi_len = 0;
        hbad = 0; idle_bad = 0; seen_frame = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (cs_n && sclk) idle_bad = 1;
            if (!cs_n && prev_cs) begin
                if (seen_frame)
                    check(hi_len >= CS_GAP, "R11", "cs high gap", hi_len, CS_GAP);
                rises = 0; lowc = 0; highc = 0; hbad = 0;
            end else if (!cs_n) begin
                if (sclk && !prev_sclk) begin
                    rises++;
                    if (rises == 1) lead = lowc;
                    if (rises == 9) mid = lowc;
                    lowc = 0;
                end
                if (!sclk && prev_sclk) begin
                    if (highc != HALF_CYC) hbad = 1;
                    highc = 0;
                end
            end
            if (cs_n && !prev_cs) begin
                seen_frame = 1;
                check(rises == 16, "R4", "rising edges", rises, 16);
                check(lowc == HALF_CYC, "R4", "cs hold after last fall", lowc, HALF_CYC);
                check(lead == HALF_CYC, "R3", "lead before first rise", lead, HALF_CYC);
                check(!hbad, "R3", "high phase length", hbad, 0);
                check(mid == HALF_CYC + BYTE_GAP, "R5", "byte gap low", mid, HALF_CYC + BYTE_GAP);
                check(done === 1'b1, "R9", "done at cs rise", done, 1);
                hi_len = 0;
            end else if (done) begin
                check(0, "R9", "done away from cs rise", 1, 0);
            end
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(0, "R10", "unexpected frame", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(frame_valid === e.valid && frame_err === e.err,
                          e.err ? "R8" : "R7", "valid/err flags",
                          {frame_valid, frame_err}, {e.valid, e.err});
                    check(sample === e.data, e.err ? "R8" : "R6", "sample", sample, e.data);
                    check(chan_id === e.chan && sub_bits === e.sub,
                          e.err ? "R8" : "R6", "chan/sub",
                          {chan_id, sub_bits}, {e.chan, e.sub});
                end
            end
            if (!cs_n) begin
                if (sclk) highc++; else lowc++;
            end else begin
                hi_len++;
            end
            prev_cs   = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        held = '{valid: 1'b0, err: 1'b0, data: '0, chan: 1'b0, sub: '0};
        repeat (3) @(negedge clk);
        // R1 reset values
        check(cs_n === 1'b1 && sclk === 1'b0, "R1", "cs_n/sclk", {cs_n, sclk}, 2);
        check(busy === 1'b0 && done === 1'b0 && frame_valid === 1'b0 && frame_err === 1'b0,
              "R1", "status", {busy, done, frame_valid, frame_err}, 0);
        check(sample === 10'd0 && chan_id === 1'b0 && sub_bits === 2'd0,
              "R1", "result", sample, 0);
        rst_n = 1'b1;
        check((CLK_HZ / (2 * HALF_CYC)) <= SMAX_HZ, "R13", "sclk rate",
              CLK_HZ / (2 * HALF_CYC), SMAX_HZ);

        run_frame(mk(3'b111, 1'b0, 10'h2AA, 2'b10), 0);   // R6 R7
        run_frame(mk(3'b111, 1'b1, 10'h3FF, 2'b11), 0);
        run_frame(mk(3'b111, 1'b0, 10'h000, 2'b00), 0);
        run_frame(mk(3'b011, 1'b1, 10'h155, 2'b01), 0);   // R8
        run_frame(mk(3'b111, 1'b1, 10'h201, 2'b01), 1);   // R10
        run_frame(mk(3'b110, 1'b0, 10'h3C3, 2'b11), 0);   // R8
        run_frame(mk(3'b111, 1'b0, 10'h155, 2'b10), 0);
        run_frame(mk(3'b111, 1'b1, 10'h001, 2'b00), 0);

        // R12: sdi toggles while cs_n is high; outputs must hold
        repeat (300) @(negedge clk);
        check(sample === held.data && chan_id === held.chan && sub_bits === held.sub,
              "R12", "result held while idle", sample, held.data);
        check(cs_n === 1'b1 && busy === 1'b0 && frame_valid === 1'b1,
              "R12", "idle state", {cs_n, busy, frame_valid}, 3'b101);
        check(!idle_bad, "R2", "sclk low while cs_n high", idle_bad, 0);
        check(sb_q.size() == 0, "R7", "frames pending", sb_q.size(), 0);
        finish_run();
    end

endmodule